// File: doc/BRIEF.md
# Microcoded Two-Register Stack Processor

A minimal single-cycle processor with no instruction decoder. A small program counter addresses a fixed instruction store. Each stored word is the raw control vector for the datapath: two load enables, a source select for the top register, and a two-bit function code for the arithmetic unit. The datapath holds two 16-bit registers arranged as a two-deep stack: a top register (T) and a register beneath it (N).

The stored program reads an 8-bit switch value and leaves twenty-five times that value in T, using only push, duplicate, shift-left and add. A single-step enable gates every register update, so the program can be walked through one instruction at a time; an asynchronous clear returns the machine to its start state. T, N, the counter and the current control word are brought out for observation.

Top module: `stk_proc`

## Requirements
- R1: While `clr` is high, T, N and the counter read zero and `instr_out` shows the word at address 0 (`11000`).
- R2: On a rising clock edge with `step_en` low, T, N and the counter keep their values, whatever the switches do.
- R3: The push word `11000` (bit 4 = N load, bit 3 = T load, bit 2 = 0 selects switches) loads T with the switches zero-extended to 16 bits and loads N with the previous T.
- R4: The duplicate word `10000` copies T into N and leaves T unchanged.
- R5: The add word `01100` (bit 2 = 1 selects the arithmetic result, bits 1:0 = 00) loads T with T+N modulo 2^16 and leaves N unchanged.
- R6: The double word `01111` (function code 11) loads T with T shifted left by one, zero filled, leaving N unchanged.
- R7: Addresses 0 to 8 hold, in order: push, duplicate, double, double, add, duplicate, double, double, add.
- R8: Addresses 9 to 15 hold `00000`, and stepping through them changes neither T nor N.
- R9: Each enabled step advances the counter by one, and the counter wraps from 15 to 0.
- R10: After clear and nine steps, T equals 25 times the switch value (0x052D for switches 0x35).
- R11: Raising `clr` zeroes T, N and the counter at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Asynchronous clear, active high |
| step_en | input | 1 | Enables one state update per rising edge |
| sw | input | 8 | Switch value pushed by the push word |
| t_out | output | 16 | Top register T |
| n_out | output | 16 | Second register N |
| pc_out | output | 4 | Program counter |
| instr_out | output | 5 | Control word at the current address |

## Verification
Every state element is visible at the ports, so a wrong register value, wrong load enable or wrong stored word shows at the next falling edge after the enabled step that caused it. The bench runs a cycle-accurate model built from the encodings above and compares T, N, the counter and the control word after every step, so a fault in a rarely used word (the idle tail or the wrap) is caught the step it executes rather than only in the final product. The final product for several switch values then checks the arithmetic chain end to end.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int DATA_W = 16;
    localparam int SW_W   = 8;
    localparam int PC_W   = 4;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_INC = 2'b01,
        ALU_NOT = 2'b10,
        ALU_DBL = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic    n_ld;
        logic    t_ld;
        logic    src_alu;
        alu_op_e op;
    } ctrl_t;

    localparam ctrl_t W_PUSH = '{n_ld: 1'b1, t_ld: 1'b1, src_alu: 1'b0, op: ALU_ADD};
    localparam ctrl_t W_ADD  = '{n_ld: 1'b0, t_ld: 1'b1, src_alu: 1'b1, op: ALU_ADD};
    localparam ctrl_t W_INC  = '{n_ld: 1'b0, t_ld: 1'b1, src_alu: 1'b1, op: ALU_INC};
    localparam ctrl_t W_NOT  = '{n_ld: 1'b0, t_ld: 1'b1, src_alu: 1'b1, op: ALU_NOT};
    localparam ctrl_t W_DBL  = '{n_ld: 1'b0, t_ld: 1'b1, src_alu: 1'b1, op: ALU_DBL};
    localparam ctrl_t W_DUP  = '{n_ld: 1'b1, t_ld: 1'b0, src_alu: 1'b0, op: ALU_ADD};
    localparam ctrl_t W_IDLE = '0;

    // Fixed program: x5 then x5 again.
    function automatic ctrl_t prog_word(input int unsigned addr);
        case (addr)
            0:       return W_PUSH;
            1:       return W_DUP;
            2:       return W_DBL;
            3:       return W_DBL;
            4:       return W_ADD;
            5:       return W_DUP;
            6:       return W_DBL;
            7:       return W_DBL;
            8:       return W_ADD;
            default: return W_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/stk_pc.sv
module stk_pc #(
    parameter int PW = stk_pkg::PC_W
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          step_en,
    output logic [PW-1:0] pc_q
);

    always_ff @(posedge clk or posedge clr) begin
        if (clr)
            pc_q <= '0;
        else if (step_en)
            pc_q <= pc_q + PW'(1);
    end

    assert_pc_hold_R2: assert property (@(posedge clk) disable iff (clr)
        !step_en |=> $stable(pc_q));

    assert_pc_step_R9: assert property (@(posedge clk) disable iff (clr)
        step_en |=> (pc_q == PW'($past(pc_q) + PW'(1))));

endmodule

// File: rtl/stk_rom.sv
module stk_rom #(
    parameter int PW = stk_pkg::PC_W
) (
    input  logic [PW-1:0]  addr,
    output stk_pkg::ctrl_t word
);

    localparam int DEPTH = 2 ** PW;

    stk_pkg::ctrl_t table_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        assign table_q[i] = stk_pkg::prog_word(i);
    end

    assign word = table_q[addr];

endmodule

// File: rtl/stk_datapath.sv
module stk_datapath #(
    parameter int DW  = stk_pkg::DATA_W,
    parameter int SWW = stk_pkg::SW_W
) (
    input  logic           clk,
    input  logic           clr,
    input  logic           step_en,
    input  stk_pkg::ctrl_t ctrl,
    input  logic [SWW-1:0] sw,
    output logic [DW-1:0]  t_q,
    output logic [DW-1:0]  n_q
);
    import stk_pkg::*;

    localparam int PADW = DW - SWW;

    logic [DW-1:0] alu_y;
    logic [DW-1:0] t_d;

    always_comb begin
        case (ctrl.op)
            ALU_ADD: alu_y = t_q + n_q;
            ALU_INC: alu_y = t_q + DW'(1);
            ALU_NOT: alu_y = ~t_q;
            default: alu_y = {t_q[DW-2:0], 1'b0};
        endcase
    end

    assign t_d = ctrl.src_alu ? alu_y : {{PADW{1'b0}}, sw};

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            t_q <= '0;
            n_q <= '0;
        end else if (step_en) begin
            if (ctrl.t_ld) t_q <= t_d;
            if (ctrl.n_ld) n_q <= t_q;
        end
    end

    assert_reg_hold_R2: assert property (@(posedge clk) disable iff (clr)
        !step_en |=> ($stable(t_q) && $stable(n_q)));

    assert_push_copy_R3: assert property (@(posedge clk) disable iff (clr)
        (step_en && ctrl.n_ld) |=> (n_q == $past(t_q)));

    assert_add_sum_R5: assert property (@(posedge clk) disable iff (clr)
        (step_en && ctrl == W_ADD) |=> (t_q == DW'($past(t_q) + $past(n_q))));

    assert_idle_word_R8: assert property (@(posedge clk) disable iff (clr)
        (step_en && ctrl == W_IDLE) |=> ($stable(t_q) && $stable(n_q)));

endmodule

// File: rtl/stk_proc.sv
module stk_proc (
    input  logic        clk,
    input  logic        clr,
    input  logic        step_en,
    input  logic [7:0]  sw,
    output logic [15:0] t_out,
    output logic [15:0] n_out,
    output logic [3:0]  pc_out,
    output logic [4:0]  instr_out
);
    import stk_pkg::*;

    logic [PC_W-1:0] pc;
    ctrl_t           ctrl;

    stk_pc #(.PW(PC_W)) u_pc (
        .clk     (clk),
        .clr     (clr),
        .step_en (step_en),
        .pc_q    (pc)
    );

    stk_rom #(.PW(PC_W)) u_rom (
        .addr (pc),
        .word (ctrl)
    );

    stk_datapath #(.DW(DATA_W), .SWW(SW_W)) u_dp (
        .clk     (clk),
        .clr     (clr),
        .step_en (step_en),
        .ctrl    (ctrl),
        .sw      (sw),
        .t_q     (t_out),
        .n_q     (n_out)
    );

    assign pc_out    = pc;
    assign instr_out = ctrl;

endmodule

// File: tb/tb_stk_proc.sv
module tb_stk_proc;

    logic        clk = 1'b0;
    logic        clr = 1'b1;
    logic        step_en = 1'b0;
    logic [7:0]  sw = 8'h00;
    logic [15:0] t_out, n_out;
    logic [3:0]  pc_out;
    logic [4:0]  instr_out;

    int n_run  = 0;
    int n_fail = 0;

    logic [15:0] mt, mn;
    logic [3:0]  mp;

    always #5 clk = ~clk;

    stk_proc dut (
        .clk(clk), .clr(clr), .step_en(step_en), .sw(sw),
        .t_out(t_out), .n_out(n_out), .pc_out(pc_out), .instr_out(instr_out)
    );

    function automatic logic [4:0] exp_word(input logic [3:0] a);
        case (a)
            4'd0: return 5'b11000;
            4'd1, 4'd5: return 5'b10000;
            4'd2, 4'd3, 4'd6, 4'd7: return 5'b01111;
            4'd4, 4'd8: return 5'b01100;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] w);
        case (w)
            5'b11000: return "R3";
            5'b10000: return "R4";
            5'b01100: return "R5";
            5'b01111: return "R6";
            default:  return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        check("R1", "T on clear", t_out, 16'h0);
        check("R1", "N on clear", n_out, 16'h0);
        check("R1", "PC on clear", {12'h0, pc_out}, 16'h0);
        check("R1", "word at 0", {11'h0, instr_out}, 16'h18);
        clr = 1'b0;
        mt = '0; mn = '0; mp = '0;
    endtask

    // One enabled step, then compare against the model.
    task automatic step_check();
        logic [4:0] w;
        logic [15:0] nt;
        string tg;
        w  = exp_word(mp);
        tg = tag_of(w);
        check("R7", "word before step", {11'h0, instr_out}, {11'h0, w});
        nt = mt;
        if (w[3]) begin
            if (!w[2]) nt = {8'h00, sw};
            else case (w[1:0])
                2'b00: nt = mt + mn;
                2'b01: nt = mt + 16'd1;
                2'b10: nt = ~mt;
                default: nt = {mt[14:0], 1'b0};
            endcase
        end
        if (w[4]) mn = mt;
        mt = nt;
        mp = mp + 4'd1;
        @(negedge clk) step_en = 1'b1;
        @(negedge clk) step_en = 1'b0;
        check(tg, "T after step", t_out, mt);
        check(tg, "N after step", n_out, mn);
        check("R9", "PC after step", {12'h0, pc_out}, {12'h0, mp});
    endtask

    task automatic t_hold();
        logic [15:0] t0, n0;
        logic [3:0] p0;
        do_clear();
        sw = 8'h5A;
        step_check();
        t0 = t_out; n0 = n_out; p0 = pc_out;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk) sw = sw ^ 8'hFF;
        end
        check("R2", "T held", t_out, t0);
        check("R2", "N held", n_out, n0);
        check("R2", "PC held", {12'h0, pc_out}, {12'h0, p0});
    endtask

    task automatic t_product(input logic [7:0] v);
        do_clear();
        sw = v;
        for (int i = 0; i < 9; i++) step_check();
        check("R10", "25x product", t_out, 16'(v) * 16'd25);
    endtask

    task automatic t_wrap();
        do_clear();
        sw = 8'h35;
        for (int i = 0; i < 16; i++) step_check();
        check("R9", "PC wrapped", {12'h0, pc_out}, 16'h0);
        check("R8", "T kept over tail", t_out, 16'h052D);
        sw = 8'h07;
        step_check();
        check("R3", "second push N", n_out, 16'h052D);
    endtask

    task automatic t_async_clear();
        do_clear();
        sw = 8'h35;
        for (int i = 0; i < 3; i++) step_check();
        #2 clr = 1'b1;
        #1;
        check("R11", "T async", t_out, 16'h0);
        check("R11", "N async", n_out, 16'h0);
        check("R11", "PC async", {12'h0, pc_out}, 16'h0);
        @(negedge clk) clr = 1'b0;
    endtask

    initial begin
        #(10 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_clear();
        t_hold();
        t_product(8'h35);
        check("R10", "0x35 gives 0x052D", t_out, 16'h052D);
        t_product(8'hFF);
        t_product(8'h01);
        t_product(8'h00);
        t_wrap();
        t_async_clear();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule